// File: doc/BRIEF.md
# Dual-Channel Wiper Register Controller with I2C Slave Front End

This block is the digital front end of a two-channel digital potentiometer. It answers on an I2C bus at a 7-bit address. The upper five bits of that address are fixed, and the lower two come from strap pins, so four devices can share one bus. A write transfer has three parts: the address byte, an instruction byte and a data byte. The instruction byte picks one of two 8-bit wiper registers and carries three more controls: a reset-to-midscale request, a soft shutdown bit and two bits that are latched onto general-purpose logic outputs. The data byte then loads the selected register.

A read transfer returns the register picked by the most recent channel-select bit. The shutdown output is high when the active-low shutdown pin is low or when the soft shutdown bit is set. The pin path has no clock in it. Shutdown never alters the stored register values.

The SCL and SDA lines are brought in through synchronizers. START and STOP are found from SDA edges while SCL is high. The open-drain SDA driver appears as an output enable: when it is high, the pad pulls the line low.

Top module: `dpot_i2c_ctrl`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 01011 followed by strap[1] and then strap[0]. The last bit of the address byte selects the direction: 0 means write and 1 means read.
- R2: If the address does not match, the slave drives SDA low on none of the following clocks. Bytes sent before the next START change no register and no output.
- R3: Instruction byte, MSB first: bit 7 selects the channel (0 selects wiper_ch0, 1 selects wiper_ch1). Bit 6 is the midscale reset. Bit 5 is the soft shutdown. Bit 4 drives gpo[0] and bit 3 drives gpo[1]. Bits 2..0 are ignored. The data byte that follows, MSB first, loads the selected channel.
- R4: During a write, the slave pulls SDA low on the ninth clock of the address byte, of the instruction byte and of the data byte.
- R5: If the instruction byte has bit 6 set, the selected channel loads 0x80 and the data byte that follows is discarded.
- R6: The shutdown output is high whenever shdn_n is low or the latched soft shutdown bit is 1. The shdn_n path needs no clock edge.
- R7: Entering or leaving shutdown leaves both wiper registers unchanged.
- R8: A read returns the register of the channel named by the last instruction byte, MSB first. The same value is sent again after each master ACK. After a master NACK the slave releases SDA.
- R9: A repeated START restarts address decoding at any point in a transfer. A STOP returns the slave to idle with SDA released.
- R10: Reset sets both wiper registers to 0x80, clears gpo and the soft shutdown bit, and releases SDA.
- R11: A transfer changes at most one wiper register. Wipers and gpo change only in the cycle after a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | I2C clock line as seen at the pad |
| sda_in | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | High pulls SDA low (open-drain enable) |
| strap | input | 2 | Address strap pins, low address bits |
| shdn_n | input | 1 | Active-low shutdown pin |
| wiper_ch0 | output | 8 | Channel 0 wiper register |
| wiper_ch1 | output | 8 | Channel 1 wiper register |
| gpo | output | 2 | Latched general-purpose logic outputs |
| shutdown | output | 1 | Combined shutdown indication |

## Verification
The assertions check the following rules on every cycle:
- Only one wiper can change at a time.
- Wipers and logic outputs change only just after a detected SCL fall.
- The SDA enable moves only on SCL falls, START or STOP, and it is released after a STOP.
- The shutdown output can drop only while the pin is high.

Other behaviour can only be shown by the bench scenarios. These cover address matching against the straps, the bit positions in the instruction byte, the discarded data after a midscale reset, the read of the last selected channel, and recovery through repeated START.

// File: rtl/dpot_pkg.sv
package dpot_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_INSTR,
      ST_INSTR_ACK,
      ST_DATA,
      ST_DATA_ACK,
      ST_RD,
      ST_RD_ACK,
      ST_HOLD
   } bus_state_t;

   // fixed upper part of the slave address
   localparam logic [4:0] DEV_ID_DEFAULT = 5'b01011;

endpackage

// File: rtl/dpot_sync_bit.sv
module dpot_sync_bit #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("dpot_sync_bit: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/dpot_bus_events.sv
module dpot_bus_events #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic sda_in,
   output logic sda_q,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw, synced, prev;

   assign raw = {scl_in, sda_in};

   for (genvar i = 0; i < NLINES; i++) begin : g_line
      dpot_sync_bit #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
         .clk  (clk),
         .rst_n(rst_n),
         .d    (raw[i]),
         .q    (synced[i])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= '1;
      else        prev <= synced;
   end

   logic scl_s, scl_p, sda_p;
   assign scl_s = synced[1];
   assign scl_p = prev[1];
   assign sda_q = synced[0];
   assign sda_p = prev[0];

   assign scl_rise  =  scl_s & ~scl_p;
   assign scl_fall  = ~scl_s &  scl_p;
   assign start_det =  scl_s &  scl_p &  sda_p & ~sda_q;
   assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_q;
endmodule

// File: rtl/dpot_wiper_bank.sv
module dpot_wiper_bank #(
   parameter int            W       = 8,
   parameter int            NCH     = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [$clog2(NCH)-1:0]       wr_sel,
   input  logic [W-1:0]                 wr_val,
   output logic [NCH-1:0][W-1:0]        q
);
   localparam int SEL_W = $clog2(NCH);

   if (NCH < 2) begin : g_bad_nch
      $error("dpot_wiper_bank: NCH must be at least 2");
   end

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic [W-1:0] r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   r <= RST_VAL;
         else if (wr_en && wr_sel == SEL_W'(i))        r <= wr_val;
      end
      assign q[i] = r;
   end
endmodule

// File: rtl/dpot_i2c_ctrl.sv
module dpot_i2c_ctrl
   import dpot_pkg::*;
#(
   parameter logic [4:0] DEV_ID      = DEV_ID_DEFAULT,
   parameter int         DATA_W      = 8,
   parameter int         SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_in,
   input  logic              sda_in,
   output logic              sda_oe,
   input  logic [1:0]        strap,
   input  logic              shdn_n,
   output logic [DATA_W-1:0] wiper_ch0,
   output logic [DATA_W-1:0] wiper_ch1,
   output logic [1:0]        gpo,
   output logic              shutdown
);
   if (DATA_W != 8) begin : g_bad_width
      $error("dpot_i2c_ctrl: the byte protocol needs DATA_W == 8");
   end

   localparam int                BIT_CW   = $clog2(DATA_W + 1);
   localparam logic [DATA_W-1:0] MIDSCALE = DATA_W'(1) << (DATA_W - 1);
   localparam int                IB_SEL   = DATA_W - 1;
   localparam int                IB_RS    = DATA_W - 2;
   localparam int                IB_SD    = DATA_W - 3;
   localparam int                IB_O1    = DATA_W - 4;
   localparam int                IB_O2    = DATA_W - 5;

   logic sda_q, scl_rise, scl_fall, start_det, stop_det;

   dpot_bus_events #(.SYNC_STAGES(SYNC_STAGES)) u_events (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_in   (scl_in),
      .sda_in   (sda_in),
      .sda_q    (sda_q),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det)
   );

   bus_state_t           st;
   logic [BIT_CW-1:0]    bitcnt;
   logic [DATA_W-1:0]    shreg, txreg;
   logic                 rw_q, sel_q, rs_q, sd_q, ack_q, nack_q;
   logic [1:0]           gpo_q;
   logic                 wr_en, wr_sel;
   logic [DATA_W-1:0]    wr_val;
   logic [1:0][DATA_W-1:0] wq;

   wire        byte_done = scl_fall && (bitcnt == BIT_CW'(DATA_W));
   wire        rx_shift  = scl_rise && (bitcnt != BIT_CW'(DATA_W));
   wire [6:0]  my_addr   = {DEV_ID, strap};
   wire [DATA_W-1:0] rd_val = wq[sel_q];

   always_comb begin
      wr_en  = 1'b0;
      wr_sel = sel_q;
      wr_val = shreg;
      if (byte_done && st == ST_INSTR && shreg[IB_RS]) begin
         wr_en  = 1'b1;
         wr_sel = shreg[IB_SEL];
         wr_val = MIDSCALE;
      end else if (byte_done && st == ST_DATA && !rs_q) begin
         wr_en  = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE;  bitcnt <= '0;  shreg <= '0;  txreg <= '0;
         rw_q <= 1'b0;   sel_q <= 1'b0; rs_q <= 1'b0; sd_q <= 1'b0;
         ack_q <= 1'b0;  nack_q <= 1'b0; gpo_q <= '0;
      end else if (start_det) begin
         st <= ST_ADDR;  bitcnt <= '0;  ack_q <= 1'b0;
      end else if (stop_det) begin
         st <= ST_IDLE;  ack_q <= 1'b0;
      end else begin
         if (rx_shift && (st == ST_ADDR || st == ST_INSTR || st == ST_DATA)) begin
            shreg  <= {shreg[DATA_W-2:0], sda_q};
            bitcnt <= bitcnt + BIT_CW'(1);
         end
         case (st)
            ST_ADDR: if (byte_done) begin
               bitcnt <= '0;
               if (shreg[DATA_W-1 -: 7] == my_addr) begin
                  ack_q <= 1'b1;
                  rw_q  <= shreg[0];
                  st    <= ST_ADDR_ACK;
               end else begin
                  st    <= ST_HOLD;
               end
            end
            ST_ADDR_ACK: if (scl_fall) begin
               ack_q <= 1'b0;
               if (rw_q) begin
                  st    <= ST_RD;
                  txreg <= rd_val;
               end else begin
                  st    <= ST_INSTR;
               end
            end
            ST_INSTR: if (byte_done) begin
               sel_q  <= shreg[IB_SEL];
               rs_q   <= shreg[IB_RS];
               sd_q   <= shreg[IB_SD];
               gpo_q  <= {shreg[IB_O2], shreg[IB_O1]};
               ack_q  <= 1'b1;
               bitcnt <= '0;
               st     <= ST_INSTR_ACK;
            end
            ST_INSTR_ACK: if (scl_fall) begin
               ack_q <= 1'b0;
               st    <= ST_DATA;
            end
            ST_DATA: if (byte_done) begin
               ack_q  <= 1'b1;
               bitcnt <= '0;
               st     <= ST_DATA_ACK;
            end
            ST_DATA_ACK: if (scl_fall) begin
               ack_q <= 1'b0;
               st    <= ST_HOLD;
            end
            ST_RD: if (scl_fall) begin
               if (bitcnt == BIT_CW'(DATA_W - 1)) begin
                  bitcnt <= '0;
                  st     <= ST_RD_ACK;
               end else begin
                  bitcnt <= bitcnt + BIT_CW'(1);
                  txreg  <= {txreg[DATA_W-2:0], 1'b0};
               end
            end
            ST_RD_ACK: begin
               if (scl_rise) nack_q <= sda_q;
               if (scl_fall) begin
                  if (nack_q) st <= ST_HOLD;
                  else begin
                     txreg <= rd_val;
                     st    <= ST_RD;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   dpot_wiper_bank #(.W(DATA_W), .NCH(2), .RST_VAL(MIDSCALE)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .wr_en (wr_en),
      .wr_sel(wr_sel),
      .wr_val(wr_val),
      .q     (wq)
   );

   assign wiper_ch0 = wq[0];
   assign wiper_ch1 = wq[1];
   assign gpo       = gpo_q;
   assign sda_oe    = ack_q | (st == ST_RD && !txreg[DATA_W-1]);
   assign shutdown  = ~shdn_n | sd_q;
endmodule

// File: rtl/dpot_i2c_ctrl_chk.sv
module dpot_i2c_ctrl_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         shdn_n,
   input logic         shutdown,
   input logic         sda_oe,
   input logic [W-1:0] wiper_ch0,
   input logic [W-1:0] wiper_ch1,
   input logic [1:0]   gpo,
   input logic         scl_fall,
   input logic         start_det,
   input logic         stop_det
);
   // R11
   single_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_ch0) |-> $stable(wiper_ch1));

   // R11
   wiper0_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_ch0) |-> $past(scl_fall));

   // R11
   wiper1_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wiper_ch1) |-> $past(scl_fall));

   // R3
   gpo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gpo) |-> $past(scl_fall));

   // R4
   sda_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> $past(scl_fall || start_det || stop_det));

   // R9
   stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> !sda_oe);

   // R6
   shutdown_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(shutdown) |-> shdn_n);
endmodule

bind dpot_i2c_ctrl dpot_i2c_ctrl_chk #(.W(DATA_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .shdn_n   (shdn_n),
   .shutdown (shutdown),
   .sda_oe   (sda_oe),
   .wiper_ch0(wiper_ch0),
   .wiper_ch1(wiper_ch1),
   .gpo      (gpo),
   .scl_fall (scl_fall),
   .start_det(start_det),
   .stop_det (stop_det)
);

// File: tb/dpot_i2c_ctrl_test.sv
module dpot_i2c_ctrl_test;
   localparam int         Q   = 8;
   localparam logic [4:0] DEV = 5'b01011;

   logic       clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1, shdn_n = 1'b1;
   logic [1:0] strap = 2'b10;
   logic       sda_oe, shutdown;
   logic [7:0] w0, w1;
   logic [1:0] gpo;
   wire        sda_line = sda_m & ~sda_oe;

   int checks = 0, errors = 0;
   logic done = 1'b0;

   always #2 clk = ~clk;

   dpot_i2c_ctrl uut (
      .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
      .sda_oe(sda_oe), .strap(strap), .shdn_n(shdn_n),
      .wiper_ch0(w0), .wiper_ch1(w1), .gpo(gpo), .shutdown(shutdown)
   );

   // instr, data, exp w0, exp w1, exp gpo, exp shutdown
   localparam int NV = 9;
   localparam logic [34:0] VEC [NV] = '{
      {8'h00, 8'h3C, 8'h3C, 8'h80, 2'b00, 1'b0},
      {8'h80, 8'hA5, 8'h3C, 8'hA5, 2'b00, 1'b0},
      {8'h10, 8'hFF, 8'hFF, 8'hA5, 2'b01, 1'b0},
      {8'h08, 8'h00, 8'h00, 8'hA5, 2'b10, 1'b0},
      {8'h9F, 8'h5A, 8'h00, 8'h5A, 2'b11, 1'b0},
      {8'hC0, 8'h11, 8'h00, 8'h80, 2'b00, 1'b0},  // midscale reset, data dropped
      {8'h40, 8'h22, 8'h80, 8'h80, 2'b00, 1'b0},  // midscale reset, data dropped
      {8'h20, 8'h77, 8'h77, 8'h80, 2'b00, 1'b1},
      {8'h00, 8'h01, 8'h01, 8'h80, 2'b00, 1'b0}
   };

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic bus_start();
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      sda_m = 1'b1; tick(Q);
   endtask

   task automatic send_bit(input logic b);
      sda_m = b;    tick(Q);
      scl_m = 1'b1; tick(2 * Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic recv_bit(output logic b);
      sda_m = 1'b1; tick(Q);
      scl_m = 1'b1; tick(Q);
      b = sda_line; tick(Q);
      scl_m = 1'b0; tick(Q);
   endtask

   task automatic write_byte(input logic [7:0] v, output logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) send_bit(v[i]);
      recv_bit(b);
      ack = ~b;
   endtask

   task automatic read_byte(output logic [7:0] v, input logic ack);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         recv_bit(b);
         v[i] = b;
      end
      send_bit(~ack);
   endtask

   task automatic write_xfer(input logic [6:0] a, input logic [7:0] ins, input logic [7:0] d,
                             output logic [2:0] acks);
      logic a0, a1, a2;
      bus_start();
      write_byte({a, 1'b0}, a0);
      write_byte(ins, a1);
      write_byte(d, a2);
      bus_stop();
      acks = {a0, a1, a2};
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [2:0] acks;
      logic       ak;
      logic [7:0] rv;

      tick(5);
      rst_n = 1'b1;
      tick(5);
      // R10 reset state
      check("R10", {w0, w1, gpo, shutdown, sda_oe}, {8'h80, 8'h80, 2'b00, 1'b0, 1'b0});

      for (int i = 0; i < NV; i++) begin
         write_xfer({DEV, strap}, VEC[i][34:27], VEC[i][26:19], acks);
         check("R4", acks, 3'b111);
         check("R3", {w0, w1, gpo}, {VEC[i][18:11], VEC[i][10:3], VEC[i][2:1]});
         check("R6", shutdown, VEC[i][0]);
      end

      // R5: midscale reset on channel 0 drops data 0x99
      write_xfer({DEV, strap}, 8'h40, 8'h99, acks);
      check("R5", {w0, w1}, {8'h80, 8'h80});
      write_xfer({DEV, strap}, 8'h00, 8'h01, acks);

      // R2: wrong low address bits, nothing acknowledged, nothing changed
      write_xfer({DEV, 2'b11}, 8'h98, 8'h99, acks);
      check("R2", acks, 3'b000);
      check("R2", {w0, w1, gpo, shutdown}, {8'h01, 8'h80, 2'b00, 1'b0});

      // R1: straps move the address
      strap = 2'b01;
      write_xfer({DEV, 2'b10}, 8'h80, 8'h55, acks);
      check("R1", {acks, w1}, {3'b000, 8'h80});
      write_xfer({DEV, 2'b01}, 8'h80, 8'h6B, acks);
      check("R1", {acks, w1}, {3'b111, 8'h6B});

      // R8: read of last selected channel (1), resent after ACK
      bus_start();
      write_byte({DEV, strap, 1'b1}, ak);
      check("R8", ak, 1'b1);
      read_byte(rv, 1'b1);
      check("R8", rv, 8'h6B);
      read_byte(rv, 1'b0);
      check("R8", rv, 8'h6B);
      check("R8", sda_oe, 1'b0);
      bus_stop();
      // R9 released after STOP
      check("R9", sda_oe, 1'b0);

      // R9: instruction only, then repeated START into a read of channel 0
      bus_start();
      write_byte({DEV, strap, 1'b0}, ak);
      write_byte(8'h00, ak);
      bus_start();
      write_byte({DEV, strap, 1'b1}, ak);
      check("R9", ak, 1'b1);
      read_byte(rv, 1'b0);
      check("R8", rv, 8'h01);
      bus_stop();

      // R9: abandoned write, then repeated START write completes
      bus_start();
      write_byte({DEV, strap, 1'b0}, ak);
      write_byte(8'h80, ak);
      bus_start();
      write_byte({DEV, strap, 1'b0}, ak);
      write_byte(8'h00, ak);
      write_byte(8'h44, ak);
      bus_stop();
      check("R9", {w0, w1}, {8'h44, 8'h6B});

      // R6 / R7: pin shutdown without clock edges, registers kept
      shdn_n = 1'b0;
      #1;
      check("R6", shutdown, 1'b1);
      tick(10);
      check("R7", {w0, w1}, {8'h44, 8'h6B});
      shdn_n = 1'b1;
      #1;
      check("R6", shutdown, 1'b0);
      check("R7", {w0, w1}, {8'h44, 8'h6B});

      // R10: reset clears soft shutdown and outputs
      write_xfer({DEV, strap}, 8'h30, 8'h12, acks);
      check("R3", {w0, gpo, shutdown}, {8'h12, 2'b01, 1'b1});
      rst_n = 1'b0;
      tick(3);
      rst_n = 1'b1;
      tick(3);
      check("R10", {w0, w1, gpo, shutdown, sda_oe}, {8'h80, 8'h80, 2'b00, 1'b0, 1'b0});

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule